// File: doc/BRIEF.md
# Two-Wire Bridge Command Decoder

This block turns a pair of logic command inputs into gate enables for an H-bridge made of two half-bridge legs. Each leg has one high-side and one low-side enable. The two command bits select one of four bridge modes. Forward drives leg A high and leg B low. Reverse is the mirror image. Brake turns on both low sides. Coast turns every gate off. The gate enables are registered, so every decision shows on the outputs one clock after the inputs are sampled.

A coast command that is held without a break for a set time puts the block into a low-power standby state. The first non-coast command clears standby. It also emits a one-clock wake pulse for the fault supervisor and starts a settling window during which all gates stay off. While the current chopper flags a trip in forward or reverse, the driven leg takes its high/low enables from the chopper's leg override instead of the static pattern. A fault-kill input overrides every mode. The clock frequency is a parameter, and both time windows are derived from it.

Top module: `bridge_cmd_decoder`

## Requirements
- R1: With cmd_a=1 and cmd_b=0 (forward), the clock edge that samples them sets gate_a_hi and gate_b_lo and clears gate_a_lo and gate_b_hi.
- R2: With cmd_a=0 and cmd_b=1 (reverse), the sampling edge sets gate_b_hi and gate_a_lo and clears gate_a_hi and gate_b_lo.
- R3: With cmd_a=1 and cmd_b=1 (brake), the sampling edge sets both low-side gates and clears both high-side gates. Trip and chopper inputs have no effect in this mode.
- R4: With cmd_a=0 and cmd_b=0 (coast), the sampling edge clears all four gates. Trip and chopper inputs have no effect in this mode.
- R5: standby rises at the edge that samples the coast command for the STANDBY_US x CLK_HZ/1e6-th consecutive time. Any non-coast sample restarts this count.
- R6: A non-coast sample while in standby clears standby at that edge. wake_pulse is high for exactly the one following clock cycle.
- R7: After the edge that leaves standby, the gates stay off for that edge and for the next WAKEUP_US x CLK_HZ/1e6 edges. Normal decoding resumes on the edge after that.
- R8: In forward (or reverse) with trip_active=1, leg A (or leg B) takes hi=chop_hi and lo=chop_lo. The other leg keeps its static state.
- R9: If chop_hi and chop_lo are both 1 while a leg follows the chopper, both gates of that leg are turned off. No leg ever has both gates on.
- R10: fault_kill=1 clears all four gates at the next edge, in every mode and with any trip or chopper input.
- R11: While rst is high, all gates, standby and wake_pulse are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_a | input | 1 | Command bit A (high selects forward drive of leg A) |
| cmd_b | input | 1 | Command bit B (high selects forward drive of leg B) |
| fault_kill | input | 1 | Forces all gates off |
| trip_active | input | 1 | Current chopper is in a decay phase |
| chop_hi | input | 1 | Chopper high-side request for the driven leg |
| chop_lo | input | 1 | Chopper low-side request for the driven leg |
| gate_a_hi | output | 1 | Leg A high-side enable |
| gate_a_lo | output | 1 | Leg A low-side enable |
| gate_b_hi | output | 1 | Leg B high-side enable |
| gate_b_lo | output | 1 | Leg B low-side enable |
| standby | output | 1 | Low-power standby state |
| wake_pulse | output | 1 | One-cycle pulse when standby is left |

## Verification
Every command pair is applied with trip low, and this separates the four static gate patterns from each other. Forward and reverse are then run with a trip and each chopper pair, which shows which leg follows the chopper and that a conflicting request turns the leg off. Trip with brake or coast shows that the chopper is ignored outside a driving mode, and fault rows show that the kill wins over every mode. Directed sequences cover these cases:
- a coast run broken by one brake sample, which shows that the standby count restarts;
- an unbroken coast run, checked one edge before and at the count limit;
- a forward command that leaves standby, followed edge by edge through the wake pulse and the settling window until forward drive appears.

// File: rtl/bridge_cmd_pkg.sv
package bridge_cmd_pkg;

    // Command encoding is {cmd_a, cmd_b}
    typedef enum logic [1:0] {
        MODE_COAST = 2'b00,
        MODE_REV   = 2'b01,
        MODE_FWD   = 2'b10,
        MODE_BRAKE = 2'b11
    } bridge_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    // Packed order: {a.hi, a.lo, b.hi, b.lo}
    typedef struct packed {
        leg_gate_t leg_a;
        leg_gate_t leg_b;
    } bridge_gate_t;

    localparam int NUM_LEGS = 2;
    localparam leg_gate_t LEG_OFF  = '{hi: 1'b0, lo: 1'b0};
    localparam leg_gate_t LEG_HIGH = '{hi: 1'b1, lo: 1'b0};
    localparam leg_gate_t LEG_LOW  = '{hi: 1'b0, lo: 1'b1};

    function automatic bridge_mode_e to_mode(input logic a, input logic b);
        return bridge_mode_e'({a, b});
    endfunction

    function automatic int unsigned us_to_cycles(input int unsigned hz,
                                                 input int unsigned us);
        int unsigned c;
        c = (hz / 1_000_000) * us;
        return (c == 0) ? 1 : c;
    endfunction

    // Static drive of one leg for a mode; leg 0 is A, leg 1 is B
    function automatic leg_gate_t static_leg(input bridge_mode_e m, input int leg);
        leg_gate_t r;
        case (m)
            MODE_FWD:   r = (leg == 0) ? LEG_HIGH : LEG_LOW;
            MODE_REV:   r = (leg == 0) ? LEG_LOW  : LEG_HIGH;
            MODE_BRAKE: r = LEG_LOW;
            default:    r = LEG_OFF;
        endcase
        return r;
    endfunction

    // True when this leg is the one pulled high by the mode
    function automatic logic is_driven_leg(input bridge_mode_e m, input int leg);
        return ((m == MODE_FWD) && (leg == 0)) || ((m == MODE_REV) && (leg == 1));
    endfunction

    // Never let both switches of one leg conduct
    function automatic leg_gate_t guard_leg(input leg_gate_t l);
        return (l.hi && l.lo) ? LEG_OFF : l;
    endfunction

endpackage

// File: rtl/bc_standby_ctl.sv
module bc_standby_ctl
    import bridge_cmd_pkg::*;
#(
    parameter int unsigned STBY_CYC = 50000,
    parameter int unsigned WAKE_CYC = 10000
) (
    input  logic         clk,
    input  logic         rst,
    input  bridge_mode_e mode,
    output logic         standby_q,
    output logic         hold_active,
    output logic         wake_pulse_q
);
    localparam int STBY_W = $clog2(STBY_CYC + 1);
    localparam int HOLD_W = $clog2(WAKE_CYC + 1);
    localparam logic [STBY_W-1:0] STBY_LAST = STBY_W'(STBY_CYC - 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(WAKE_CYC);

    logic [STBY_W-1:0] coast_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              coast;

    assign coast       = (mode == MODE_COAST);
    assign hold_active = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            coast_cnt    <= '0;
            hold_cnt     <= '0;
            standby_q    <= 1'b0;
            wake_pulse_q <= 1'b0;
        end else begin
            wake_pulse_q <= 1'b0;
            if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
            if (standby_q) begin
                if (!coast) begin
                    standby_q    <= 1'b0;
                    wake_pulse_q <= 1'b1;
                    hold_cnt     <= HOLD_LOAD;
                end
            end else if (coast) begin
                if (coast_cnt == STBY_LAST) begin
                    standby_q <= 1'b1;
                    coast_cnt <= '0;
                end else begin
                    coast_cnt <= coast_cnt + 1'b1;
                end
            end else begin
                coast_cnt <= '0;
            end
        end
    end

    // R5
    stby_from_coast_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(standby_q) |-> $past(mode == MODE_COAST));

    // R6
    wake_on_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(standby_q) |-> wake_pulse_q);

    // R6
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse_q |=> !wake_pulse_q);

    // R7
    hold_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse_q |-> hold_active);

endmodule

// File: rtl/bc_gate_sel.sv
module bc_gate_sel
    import bridge_cmd_pkg::*;
(
    input  bridge_mode_e mode,
    input  logic         trip_active,
    input  leg_gate_t    chop_leg,
    input  logic         block,
    output bridge_gate_t gate_next
);
    leg_gate_t leg_sel [NUM_LEGS];

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        always_comb begin
            if (block)
                leg_sel[g] = LEG_OFF;
            else if (trip_active && is_driven_leg(mode, g))
                leg_sel[g] = guard_leg(chop_leg);
            else
                leg_sel[g] = static_leg(mode, g);
        end
    end

    assign gate_next.leg_a = leg_sel[0];
    assign gate_next.leg_b = leg_sel[1];

endmodule

// File: rtl/bc_gate_reg.sv
module bc_gate_reg
    import bridge_cmd_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  bridge_gate_t gate_next,
    output bridge_gate_t gate_q
);
    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= '0;
        else
            gate_q <= gate_next;
    end

    // R9
    leg_a_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_q.leg_a.hi && gate_q.leg_a.lo));

    // R9
    leg_b_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_q.leg_b.hi && gate_q.leg_b.lo));

endmodule

// File: rtl/bridge_cmd_decoder.sv
module bridge_cmd_decoder
    import bridge_cmd_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned STANDBY_US = 1000,
    parameter int unsigned WAKEUP_US  = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_a,
    input  logic cmd_b,
    input  logic fault_kill,
    input  logic trip_active,
    input  logic chop_hi,
    input  logic chop_lo,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo,
    output logic standby,
    output logic wake_pulse
);
    localparam int unsigned STBY_CYC = us_to_cycles(CLK_HZ, STANDBY_US);
    localparam int unsigned WAKE_CYC = us_to_cycles(CLK_HZ, WAKEUP_US);

    bridge_mode_e mode;
    leg_gate_t    chop_leg;
    logic         standby_q;
    logic         hold_active;
    logic         wake_q;
    logic         block;
    bridge_gate_t gate_next;
    bridge_gate_t gate_q;

    assign mode     = to_mode(cmd_a, cmd_b);
    assign chop_leg = '{hi: chop_hi, lo: chop_lo};
    assign block    = fault_kill || standby_q || hold_active;

    bc_standby_ctl #(
        .STBY_CYC(STBY_CYC),
        .WAKE_CYC(WAKE_CYC)
    ) u_standby (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .standby_q   (standby_q),
        .hold_active (hold_active),
        .wake_pulse_q(wake_q)
    );

    bc_gate_sel u_sel (
        .mode       (mode),
        .trip_active(trip_active),
        .chop_leg   (chop_leg),
        .block      (block),
        .gate_next  (gate_next)
    );

    bc_gate_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .gate_next(gate_next),
        .gate_q   (gate_q)
    );

    assign gate_a_hi  = gate_q.leg_a.hi;
    assign gate_a_lo  = gate_q.leg_a.lo;
    assign gate_b_hi  = gate_q.leg_b.hi;
    assign gate_b_lo  = gate_q.leg_b.lo;
    assign standby    = standby_q;
    assign wake_pulse = wake_q;

    // R10
    fault_kill_chk: assert property (@(posedge clk) disable iff (rst)
        fault_kill |=> (gate_q == '0));

    // R7
    settle_off_chk: assert property (@(posedge clk) disable iff (rst)
        (standby_q || hold_active) |=> (gate_q == '0));

    // R1
    fwd_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWD && !block && !trip_active) |=> (gate_q == 4'b1001));

    // R8
    fwd_chop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWD && !block && trip_active && chop_hi && !chop_lo)
        |=> (gate_a_hi && !gate_a_lo && gate_b_lo));

endmodule

// File: tb/bridge_cmd_decoder_bench.sv
module bridge_cmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int STBY = 40;
    localparam int WAKE = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_a = 1'b0, cmd_b = 1'b0, fault_kill = 1'b0;
    logic trip_active = 1'b0, chop_hi = 1'b0, chop_lo = 1'b0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo, standby, wake_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bridge_cmd_decoder #(
        .CLK_HZ    (1_000_000),
        .STANDBY_US(STBY),
        .WAKEUP_US (WAKE)
    ) u_bridge_cmd_decoder (
        .clk(clk), .rst(rst), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .fault_kill(fault_kill), .trip_active(trip_active),
        .chop_hi(chop_hi), .chop_lo(chop_lo),
        .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
        .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo),
        .standby(standby), .wake_pulse(wake_pulse)
    );

    // Gate vector order {a_hi, a_lo, b_hi, b_lo}
    typedef struct packed {
        logic [15:0] tag;
        logic        a, b, f, t, ch, cl;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{"R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1001},
        '{"R2", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0110},
        '{"R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0101},
        '{"R4", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{"R8", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1001},
        '{"R8", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0101},
        '{"R8", 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0100},
        '{"R9", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0001},
        '{"R9", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0100},
        '{"R3", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0101},
        '{"R4", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000},
        '{"R10", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{"R10", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0000},
        '{"R10", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000}
    };

    function automatic logic [3:0] gates();
        return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
    endfunction

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic f,
                         input logic t, input logic ch, input logic cl);
        cmd_a = a; cmd_b = b; fault_kill = f;
        trip_active = t; chop_hi = ch; chop_lo = cl;
    endtask

    // One edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset holds everything low, even with a forward command
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        step();
        check("R11", {gates(), standby, wake_pulse} >> 2, 4'b0000);
        check("R11", {2'b00, standby, wake_pulse}, 4'b0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].a, VECS[i].b, VECS[i].f, VECS[i].t, VECS[i].ch, VECS[i].cl);
            step();
            check($sformatf("%s", VECS[i].tag), gates(), VECS[i].exp);
        end

        // R5: an interrupted coast run restarts the count
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) step();
        drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < STBY - 1; k++) step();
        check("R5", {3'b000, standby}, 4'b0000);
        step();
        check("R5", {3'b000, standby}, 4'b0001);
        check("R4", gates(), 4'b0000);

        // R6: leave standby with a forward command
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        check("R6", {2'b00, standby, wake_pulse}, 4'b0001);
        check("R7", gates(), 4'b0000);
        for (int k = 1; k <= WAKE; k++) begin
            step();
            if (k == 1) check("R6", {3'b000, wake_pulse}, 4'b0000);
            check("R7", gates(), 4'b0000);
        end
        step();
        check("R7", gates(), 4'b1001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule